// File: doc/BRIEF.md
# Boot-Remappable Region Select Decoder

This block turns the top bits of a 32-bit processor address into one select out of eight, each covering a 256 MB window of the lower 2 GB. Six of the selects leave the chip as active-low strobes for external memories or expansion devices. The other two stay inside: one enables the on-chip SRAM and one enables the on-chip boot ROM. Along with the select, the block gives each internal memory its local address. The ROM receives the full region offset. The SRAM receives an offset folded into the frame-buffer size that software has programmed.

A strap input is captured for as long as power-on reset is held. When the strap is low, the chip boots from internal ROM, and the region-to-select mapping is mirrored so that the ROM answers at address zero. The mapping then stays fixed until the next power-on reset.

After reset the block holds its run-enable output low, which keeps the chip in standby. It raises run-enable only when it sees a low-to-high edge on the wake input. The wake input passes through a two-stage synchronizer before the edge is detected.

Top module: `region_select_decoder`

## Requirements
- R1: Address bits [30:28] give the region index. An address with bit 31 set lies outside all eight regions and asserts no select.
- R2: With the mirror off, region n asserts select n. Selects 0 to 5 drive `ext_cs_n[n]` low, select 6 drives `sram_sel` high and select 7 drives `rom_sel` high, so the ROM sits at 0x7000_0000.
- R3: With the mirror on, region n asserts select 7−n, so the ROM sits at 0x0000_0000 and the SRAM at 0x1000_0000.
- R4: The mirror takes the inverse of `boot_sel_n` on every clock edge while `rst` is high. Once `rst` is low, changes on `boot_sel_n` have no effect until `rst` is asserted again.
- R5: While `stb` is low, `ext_cs_n` is all ones and both `sram_sel` and `rom_sel` are low.
- R6: At most one of the eight selects is active at any time. Exactly one is active when `stb` is high and bit 31 is clear.
- R7: `rom_offset` equals address bits [27:0].
- R8: `sram_addr` equals address bits [27:0] modulo (P × 4096). P is `fb_pages`, except that a value of 0 or a value above 32 is taken as 32. The output is 17 bits wide.
- R9: `run_en` is low during reset and after reset. It rises on the third clock edge after `wake` goes from low to high, counting the first edge that samples `wake` high. If `wake` is already high when reset is released, it must first go low before a rise counts.
- R10: Once `run_en` is high, it stays high until `rst` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| boot_sel_n | input | 1 | Boot strap; low selects boot from internal ROM |
| wake | input | 1 | Asynchronous wake request |
| stb | input | 1 | Access strobe |
| addr | input | 32 | Processor address |
| fb_pages | input | 6 | Frame-buffer size in 4 KB pages |
| ext_cs_n | output | 6 | Active-low external chip selects |
| sram_sel | output | 1 | Internal SRAM select |
| rom_sel | output | 1 | Internal ROM select |
| rom_offset | output | 28 | Local ROM address |
| sram_addr | output | 17 | Local SRAM address after wrapping |
| run_en | output | 1 | Leave-standby enable |

## Verification
The hardest case to reach is the mirror holding firm once reset is over. A mirror that tracked the live strap would pass every decoding check, so the strap has to move while the decoder is being watched. The stimulus resets with the strap low, then drives it high after release and confirms that address zero still reaches the ROM. A later reset with the strap high restores the normal map. The wake path needs similar care: `wake` is held high through reset, and the bench checks that only a fresh low-to-high edge releases `run_en`, and only on the predicted cycle.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

    localparam int ADDR_W         = 32;
    localparam int REGION_W       = 3;
    localparam int NUM_SEL        = 1 << REGION_W;
    localparam int NUM_EXT        = NUM_SEL - 2;
    localparam int SEL_SRAM       = NUM_SEL - 2;
    localparam int SEL_ROM        = NUM_SEL - 1;
    localparam int OFFS_W         = ADDR_W - 1 - REGION_W;
    localparam int PAGE_W         = 12;
    localparam int SRAM_MAX_PAGES = 32;
    localparam int FB_W           = $clog2(SRAM_MAX_PAGES) + 1;
    localparam int SRAM_AW        = PAGE_W + $clog2(SRAM_MAX_PAGES);

    typedef logic [REGION_W-1:0] region_t;

    typedef struct packed {
        logic    valid;
        region_t idx;
    } sel_req_t;

    function automatic region_t map_region(region_t r, logic mirror);
        return mirror ? region_t'(NUM_SEL - 1 - int'(r)) : r;
    endfunction

endpackage

// File: rtl/rsd_boot_ctrl.sv
module rsd_boot_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic boot_sel_n,
    input  logic wake,
    output logic mirror,
    output logic run_en
);
    logic mirror_q;
    logic wake_s1, wake_s2, wake_prev;
    logic run_q;
    logic wake_rise;

    always_ff @(posedge clk) begin
        if (rst) mirror_q <= ~boot_sel_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_s1   <= 1'b1;
            wake_s2   <= 1'b1;
            wake_prev <= 1'b1;
        end else begin
            wake_s1   <= wake;
            wake_s2   <= wake_s1;
            wake_prev <= wake_s2;
        end
    end

    assign wake_rise = wake_s2 & ~wake_prev;

    always_ff @(posedge clk) begin
        if (rst)            run_q <= 1'b0;
        else if (wake_rise) run_q <= 1'b1;
    end

    assign mirror = mirror_q;
    assign run_en = run_q;

    // R4: strap capture frozen outside reset
    a_r4_mirror_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mirror_q));

    // R10: run enable is sticky
    a_r10_run_sticky: assert property (@(posedge clk) disable iff (rst)
        run_q |=> run_q);

    // R9: run enable rises only after wake was seen high two edges earlier
    a_r9_run_after_wake: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> $past(wake, 2));

endmodule

// File: rtl/rsd_region_map.sv
module rsd_region_map
    import rsd_pkg::*;
(
    input  logic               stb,
    input  logic               outside,
    input  region_t            region,
    input  logic               mirror,
    output logic [NUM_EXT-1:0] ext_cs_n,
    output logic               sram_sel,
    output logic               rom_sel
);
    sel_req_t            req;
    logic [NUM_SEL-1:0]  hit;

    always_comb begin
        req.valid = stb & ~outside;
        req.idx   = map_region(region, mirror);
    end

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        assign hit[i] = req.valid && (req.idx == region_t'(i));
    end

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
        assign ext_cs_n[i] = ~hit[i];
    end

    assign sram_sel = hit[SEL_SRAM];
    assign rom_sel  = hit[SEL_ROM];

endmodule

// File: rtl/rsd_sram_wrap.sv
module rsd_sram_wrap #(
    parameter int OFFS_W    = 28,
    parameter int PAGE_W    = 12,
    parameter int MAX_PAGES = 32,
    parameter int FB_W      = 6
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic [OFFS_W-1:0]                       offset,
    input  logic [FB_W-1:0]                         fb_pages,
    output logic [PAGE_W+$clog2(MAX_PAGES)-1:0]     sram_addr
);
    localparam int IDX_W = OFFS_W - PAGE_W;
    localparam int PN_W  = $clog2(MAX_PAGES);

    logic [FB_W-1:0]  pages;
    logic [IDX_W-1:0] page_idx;
    logic [IDX_W-1:0] page_mod;

    always_comb begin
        if (fb_pages == '0 || fb_pages > FB_W'(MAX_PAGES)) pages = FB_W'(MAX_PAGES);
        else                                               pages = fb_pages;
        page_idx = offset[OFFS_W-1:PAGE_W];
        page_mod = page_idx % IDX_W'(pages);
    end

    assign sram_addr = {page_mod[PN_W-1:0], offset[PAGE_W-1:0]};

    // R8: wrapped page always falls inside the programmed size
    a_r8_in_window: assert property (@(posedge clk) disable iff (rst)
        FB_W'(sram_addr[PAGE_W+PN_W-1:PAGE_W]) < pages);

endmodule

// File: rtl/region_select_decoder.sv
module region_select_decoder
    import rsd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  boot_sel_n,
    input  logic                  wake,
    input  logic                  stb,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [FB_W-1:0]       fb_pages,
    output logic [NUM_EXT-1:0]    ext_cs_n,
    output logic                  sram_sel,
    output logic                  rom_sel,
    output logic [OFFS_W-1:0]     rom_offset,
    output logic [SRAM_AW-1:0]    sram_addr,
    output logic                  run_en
);
    logic    mirror;
    region_t region;
    logic    outside;

    assign outside    = addr[ADDR_W-1];
    assign region     = addr[ADDR_W-2 -: REGION_W];
    assign rom_offset = addr[OFFS_W-1:0];

    rsd_boot_ctrl u_boot (
        .clk        (clk),
        .rst        (rst),
        .boot_sel_n (boot_sel_n),
        .wake       (wake),
        .mirror     (mirror),
        .run_en     (run_en)
    );

    rsd_region_map u_map (
        .stb      (stb),
        .outside  (outside),
        .region   (region),
        .mirror   (mirror),
        .ext_cs_n (ext_cs_n),
        .sram_sel (sram_sel),
        .rom_sel  (rom_sel)
    );

    rsd_sram_wrap #(
        .OFFS_W    (OFFS_W),
        .PAGE_W    (PAGE_W),
        .MAX_PAGES (SRAM_MAX_PAGES),
        .FB_W      (FB_W)
    ) u_wrap (
        .clk       (clk),
        .rst       (rst),
        .offset    (addr[OFFS_W-1:0]),
        .fb_pages  (fb_pages),
        .sram_addr (sram_addr)
    );

    // R6: never more than one select
    a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rom_sel, sram_sel, ~ext_cs_n}));

    // R5: idle strobe leaves everything inactive
    a_r5_idle: assert property (@(posedge clk) disable iff (rst)
        !stb |-> (&ext_cs_n && !sram_sel && !rom_sel));

    // R3: mirrored map puts the ROM at the bottom region
    a_r3_rom_at_zero: assert property (@(posedge clk) disable iff (rst)
        (mirror && stb && addr[ADDR_W-1 -: REGION_W+1] == '0) |-> rom_sel);

endmodule

// File: tb/region_select_decoder_test.sv
module region_select_decoder_test;
    import rsd_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 boot_sel_n;
    logic                 wake;
    logic                 stb;
    logic [ADDR_W-1:0]    addr;
    logic [FB_W-1:0]      fb_pages;
    logic [NUM_EXT-1:0]   ext_cs_n;
    logic                 sram_sel;
    logic                 rom_sel;
    logic [OFFS_W-1:0]    rom_offset;
    logic [SRAM_AW-1:0]   sram_addr;
    logic                 run_en;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    region_select_decoder uut (
        .clk(clk), .rst(rst), .boot_sel_n(boot_sel_n), .wake(wake), .stb(stb),
        .addr(addr), .fb_pages(fb_pages), .ext_cs_n(ext_cs_n), .sram_sel(sram_sel),
        .rom_sel(rom_sel), .rom_offset(rom_offset), .sram_addr(sram_addr), .run_en(run_en)
    );

    // {stb, addr, expected {rom, sram, cs5..cs0} active-high}, mirror off
    localparam int NV = 11;
    localparam logic [40:0] VEC [NV] = '{
        {1'b1, 32'h0000_0000, 8'h01},
        {1'b1, 32'h1234_5678, 8'h02},
        {1'b1, 32'h2FFF_FFFF, 8'h04},
        {1'b1, 32'h3000_0000, 8'h08},
        {1'b1, 32'h4800_0000, 8'h10},
        {1'b1, 32'h5ABC_0000, 8'h20},
        {1'b1, 32'h6000_1000, 8'h40},
        {1'b1, 32'h7000_0000, 8'h80},
        {1'b0, 32'h7000_0000, 8'h00},
        {1'b1, 32'h8000_0000, 8'h00},
        {1'b1, 32'hF000_0000, 8'h00}
    };

    function automatic logic [7:0] sel_now();
        return {rom_sel, sram_sel, ~ext_cs_n};
    endfunction

    function automatic logic [7:0] model_sel(logic s, logic [31:0] a, logic mir);
        int r;
        if (!s || a[31]) return 8'h00;
        r = int'(a[30:28]);
        if (mir) r = 7 - r;
        return 8'(1 << r);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic apply(logic s, logic [31:0] a);
        @(negedge clk);
        stb  = s;
        addr = a;
        #5;
    endtask

    task automatic do_reset(logic strap);
        @(negedge clk);
        rst = 1'b1;
        boot_sel_n = strap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; boot_sel_n = 1'b1; wake = 1'b1; stb = 1'b0;
        addr = '0; fb_pages = 6'd0;
        repeat (3) @(negedge clk);
        #5;
        check("R9 reset run_en", 64'(run_en), 64'd0);
        check("R5 reset selects", 64'(sel_now()), 64'h00);
        @(negedge clk);
        rst = 1'b0;

        // R2 R1 R5 normal map from table
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][40], VEC[i][39:8]);
            if (!VEC[i][40])      check("R5 strobe low", 64'(sel_now()), 64'(VEC[i][7:0]));
            else if (VEC[i][39])  check("R1 outside", 64'(sel_now()), 64'(VEC[i][7:0]));
            else                  check("R2 normal map", 64'(sel_now()), 64'(VEC[i][7:0]));
            check("R6 count", 64'($countones(sel_now()) <= 1), 64'd1);
        end

        // R7 ROM offset
        apply(1'b1, 32'h7ABC_DEF1);
        check("R7 rom offset", 64'(rom_offset), 64'h0ABC_DEF1);

        // R8 SRAM wrap
        fb_pages = 6'd5;
        apply(1'b1, 32'h6000_5123);
        check("R8 wrap 5 pages", 64'(sram_addr), 64'h0123);
        fb_pages = 6'd0;
        apply(1'b1, 32'h6002_1234);
        check("R8 zero clamps to 32", 64'(sram_addr), 64'h1234);
        fb_pages = 6'd40;
        apply(1'b1, 32'h6002_1234);
        check("R8 large clamps to 32", 64'(sram_addr), 64'h1234);
        fb_pages = 6'd32;
        apply(1'b1, 32'h6001_FFFF);
        check("R8 top of window", 64'(sram_addr), 64'h1FFFF);
        fb_pages = 6'd3;
        apply(1'b1, 32'h6000_2FFF);
        check("R8 below size", 64'(sram_addr), 64'h2FFF);

        // R9 wake held high through reset must not release run_en
        repeat (5) @(negedge clk);
        #5;
        check("R9 no edge yet", 64'(run_en), 64'd0);
        @(negedge clk); wake = 1'b0;
        repeat (4) @(negedge clk);
        wake = 1'b1;
        @(posedge clk); @(posedge clk); #5;
        check("R9 two edges", 64'(run_en), 64'd0);
        @(posedge clk); #5;
        check("R9 third edge", 64'(run_en), 64'd1);
        @(negedge clk); wake = 1'b0;
        repeat (5) @(negedge clk);
        #5;
        check("R10 sticky", 64'(run_en), 64'd1);

        // R4 R3 boot from ROM: strap low at reset
        do_reset(1'b0);
        #5;
        check("R10 cleared by reset", 64'(run_en), 64'd0);
        for (int r = 0; r < 8; r++) begin
            apply(1'b1, {1'b0, 3'(r), 28'h0000_040});
            check("R3 mirrored map", 64'(sel_now()), 64'(model_sel(1'b1, addr, 1'b1)));
        end
        @(negedge clk); boot_sel_n = 1'b1;
        repeat (2) @(negedge clk);
        apply(1'b1, 32'h0000_0000);
        check("R4 strap ignored after reset", 64'(sel_now()), 64'h80);
        apply(1'b1, 32'h7000_0000);
        check("R4 strap ignored top", 64'(sel_now()), 64'h01);
        apply(1'b0, 32'h0000_0000);
        check("R5 strobe low mirrored", 64'(sel_now()), 64'h00);

        // R4 new reset with strap high restores normal map
        do_reset(1'b1);
        @(negedge clk); boot_sel_n = 1'b0;
        apply(1'b1, 32'h0000_0000);
        check("R4 normal after reset", 64'(sel_now()), 64'h01);
        apply(1'b1, 32'h7000_0000);
        check("R4 rom back at top", 64'(sel_now()), 64'h80);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule